// File: doc/BRIEF.md
# Acquisition Status and Interrupt Flag Register

This block forms the 8-bit status byte of a data-acquisition front end. It brings together two kinds of flags. Some are live and simply follow the sample FIFO's level signals. Others are sticky and record that an event happened: a FIFO overrun, an on-board interrupt, an external interrupt edge, an external trigger edge, or the index counter being shut off. Each sticky flag is cleared by its own strobe. The index-gate flag and the trigger flag share one clear strobe.

A layout select input picks one of two byte layouts. The enhanced layout shows the FIFO and event flags. The compatible layout shows converter configuration and busy state for older driver software. The block also drives an interrupt request line and an index-counter enable. The enable drops as soon as the FIFO rises above half full. The selection of the four interrupt sources and the FIFO itself sit outside this block.

Top module: `acq_status_reg`

## Requirements
- R1: With `layout_sel`=1 (enhanced), `status_o` is, from bit 7 down to bit 0: pacer select (1 = fast pacer), index-gate latch, trigger latch, on-board interrupt latch, external interrupt latch, overrun latch, FIFO above half, FIFO not empty.
- R2: With `layout_sel`=0 (compatible), `status_o` is, from bit 7 down to bit 0: conversion busy, unipolar (1) / bipolar (0), single-ended (1) / differential (0), on-board interrupt latch, and `mux_addr[3:0]` in bits 3..0.
- R3: The not-empty and above-half bits are not latched. They equal `fifo_not_empty` and `fifo_above_half` in the same cycle.
- R4: A high `fifo_overrun` at a rising clock edge sets the overrun latch after that edge. The latch stays 1 until an edge with `clr_ovf` high.
- R5: A high bit of `irq_evt` at an edge sets the on-board interrupt latch. Only `clr_int` clears it. `clr_ovf`, `clr_xint` and `clr_trig` leave it unchanged.
- R6: A rising edge on `ext_irq_in` sets the external interrupt latch, and only `clr_xint` clears it. A level held high does not set it again after a clear.
- R7: A rising edge on `trig_in` sets the trigger latch, and `clr_trig` clears it.
- R8: A high `fifo_above_half` at an edge sets the index-gate latch. `index_en` is 0 while that latch is 1. `clr_trig` clears the latch.
- R9: When a set event and the matching clear strobe meet at the same edge, the latch ends at 1.
- R10: `irq_req` is 1 exactly when the on-board or the external interrupt latch is 1.
- R11: While `rst_n` is low, every latch is 0 and the edge detectors start from a low input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_sel | input | 1 | 1 = enhanced layout, 0 = compatible layout |
| fifo_not_empty | input | 1 | FIFO holds at least one sample |
| fifo_above_half | input | 1 | FIFO fill is above half capacity |
| fifo_overrun | input | 1 | Pulse: a sample arrived while the FIFO was full |
| irq_evt | input | N_IRQ_SRC | Already-selected on-board interrupt events |
| ext_irq_in | input | 1 | External interrupt line, edge sensitive |
| trig_in | input | 1 | External trigger line, edge sensitive |
| clr_ovf | input | 1 | Clear strobe for the overrun latch |
| clr_int | input | 1 | Clear strobe for the on-board interrupt latch |
| clr_xint | input | 1 | Clear strobe for the external interrupt latch |
| clr_trig | input | 1 | Clear strobe for the trigger and index-gate latches |
| pacer_fast | input | 1 | Pacer clock select (1 = fast) |
| mux_addr | input | MUX_AW | Current input multiplexer address |
| inputs_single_ended | input | 1 | 1 = single-ended inputs, 0 = differential |
| input_unipolar | input | 1 | 1 = unipolar range, 0 = bipolar |
| conv_busy | input | 1 | Conversion in progress |
| status_o | output | 8 | Status byte |
| irq_req | output | 1 | Interrupt request |
| index_en | output | 1 | Index counter enable |

## Verification
Live and configuration bits are combinational, so they are due in the same cycle the inputs change. Every latch, and therefore `irq_req` and `index_en`, changes one rising edge after the event or strobe. The bench changes inputs on the falling edge and holds them steady through the next rising edge. At that rising edge it advances its own flag model, then samples all outputs 1 ns later. The outputs then show the new latch state combined with the inputs that are still held.

// File: rtl/acq_status_pkg.sv
`timescale 1ns/1ps
package acq_status_pkg;

   localparam int STAT_W  = 8;
   localparam int N_LATCH = 5;

   // latch slot order inside the sticky bank
   localparam int SLOT_OVF  = 0;
   localparam int SLOT_XINT = 1;
   localparam int SLOT_INT  = 2;
   localparam int SLOT_TRIG = 3;
   localparam int SLOT_GATE = 4;

   typedef enum logic {
      LAYOUT_COMPAT = 1'b0,
      LAYOUT_ENH    = 1'b1
   } layout_e;

   typedef struct packed {
      logic gate;
      logic trig;
      logic intr;
      logic xint;
      logic ovf;
   } latch_t;

endpackage

// File: rtl/acq_sticky_bit.sv
`timescale 1ns/1ps
module acq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority so an event coinciding with a clear is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/acq_edge_detect.sv
`timescale 1ns/1ps
module acq_edge_detect #(
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic pulse_o
);
   logic prev_q;

   // idle level after reset is the inactive level, so no false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= FALLING;
      else        prev_q <= sig_i;
   end

   generate
      if (FALLING) begin : g_fall
         assign pulse_o = prev_q & ~sig_i;
      end else begin : g_rise
         assign pulse_o = sig_i & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/acq_status_mux.sv
`timescale 1ns/1ps
module acq_status_mux
   import acq_status_pkg::*;
#(
   parameter int MUX_AW = 4
) (
   input  layout_e             layout,
   input  latch_t              flags,
   input  logic                fifo_ne,
   input  logic                fifo_half,
   input  logic                pacer_fast,
   input  logic [MUX_AW-1:0]   mux_addr,
   input  logic                single_ended,
   input  logic                unipolar,
   input  logic                busy,
   output logic [STAT_W-1:0]   stat_o
);
   logic [STAT_W-1:0] enh_byte;
   logic [STAT_W-1:0] cmp_byte;

   always_comb begin
      enh_byte    = '0;
      enh_byte[0] = fifo_ne;
      enh_byte[1] = fifo_half;
      enh_byte[2] = flags.ovf;
      enh_byte[3] = flags.xint;
      enh_byte[4] = flags.intr;
      enh_byte[5] = flags.trig;
      enh_byte[6] = flags.gate;
      enh_byte[7] = pacer_fast;
   end

   always_comb begin
      cmp_byte             = '0;
      cmp_byte[MUX_AW-1:0] = mux_addr;
      cmp_byte[4]          = flags.intr;
      cmp_byte[5]          = single_ended;
      cmp_byte[6]          = unipolar;
      cmp_byte[7]          = busy;
   end

   always_comb begin
      unique case (layout)
         LAYOUT_ENH:    stat_o = enh_byte;
         default:       stat_o = cmp_byte;
      endcase
   end
endmodule

// File: rtl/acq_status_reg.sv
`timescale 1ns/1ps
module acq_status_reg
   import acq_status_pkg::*;
#(
   parameter int N_IRQ_SRC    = 4,
   parameter int MUX_AW       = 4,
   parameter bit TRIG_FALLING = 1'b0,
   parameter bit XINT_FALLING = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 layout_sel,
   input  logic                 fifo_not_empty,
   input  logic                 fifo_above_half,
   input  logic                 fifo_overrun,
   input  logic [N_IRQ_SRC-1:0] irq_evt,
   input  logic                 ext_irq_in,
   input  logic                 trig_in,
   input  logic                 clr_ovf,
   input  logic                 clr_int,
   input  logic                 clr_xint,
   input  logic                 clr_trig,
   input  logic                 pacer_fast,
   input  logic [MUX_AW-1:0]    mux_addr,
   input  logic                 inputs_single_ended,
   input  logic                 input_unipolar,
   input  logic                 conv_busy,
   output logic [STAT_W-1:0]    status_o,
   output logic                 irq_req,
   output logic                 index_en
);
   generate
      if (MUX_AW != 4) begin : g_bad_aw
         $error("acq_status_reg: MUX_AW must be 4 to fill the low nibble");
      end
      if (N_IRQ_SRC < 1 || N_IRQ_SRC > 8) begin : g_bad_src
         $error("acq_status_reg: N_IRQ_SRC must be 1..8");
      end
   endgenerate

   logic               xint_evt;
   logic               trig_evt;
   logic [N_LATCH-1:0] set_vec;
   logic [N_LATCH-1:0] clr_vec;
   logic [N_LATCH-1:0] q_vec;
   latch_t             latch_q;

   acq_edge_detect #(.FALLING(XINT_FALLING)) u_xint_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(ext_irq_in), .pulse_o(xint_evt));

   acq_edge_detect #(.FALLING(TRIG_FALLING)) u_trig_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(trig_in), .pulse_o(trig_evt));

   always_comb begin
      set_vec            = '0;
      clr_vec            = '0;
      set_vec[SLOT_OVF]  = fifo_overrun;
      clr_vec[SLOT_OVF]  = clr_ovf;
      set_vec[SLOT_XINT] = xint_evt;
      clr_vec[SLOT_XINT] = clr_xint;
      set_vec[SLOT_INT]  = |irq_evt;
      clr_vec[SLOT_INT]  = clr_int;
      set_vec[SLOT_TRIG] = trig_evt;
      clr_vec[SLOT_TRIG] = clr_trig;
      set_vec[SLOT_GATE] = fifo_above_half;
      clr_vec[SLOT_GATE] = clr_trig;
   end

   for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
      acq_sticky_bit u_bit (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q_o(q_vec[i]));
   end

   assign latch_q.ovf  = q_vec[SLOT_OVF];
   assign latch_q.xint = q_vec[SLOT_XINT];
   assign latch_q.intr = q_vec[SLOT_INT];
   assign latch_q.trig = q_vec[SLOT_TRIG];
   assign latch_q.gate = q_vec[SLOT_GATE];

   acq_status_mux #(.MUX_AW(MUX_AW)) u_mux (
      .layout       (layout_e'(layout_sel)),
      .flags        (latch_q),
      .fifo_ne      (fifo_not_empty),
      .fifo_half    (fifo_above_half),
      .pacer_fast   (pacer_fast),
      .mux_addr     (mux_addr),
      .single_ended (inputs_single_ended),
      .unipolar     (input_unipolar),
      .busy         (conv_busy),
      .stat_o       (status_o));

   assign irq_req  = latch_q.intr | latch_q.xint;
   assign index_en = ~latch_q.gate;
endmodule

// File: rtl/acq_status_chk.sv
`timescale 1ns/1ps
module acq_status_chk
   import acq_status_pkg::*;
#(
   parameter int N_IRQ_SRC = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fifo_overrun,
   input logic                 fifo_above_half,
   input logic [N_IRQ_SRC-1:0] irq_evt,
   input logic                 clr_ovf,
   input logic                 clr_int,
   input logic                 trig_evt,
   input latch_t               latch_q,
   input logic                 irq_req,
   input logic                 index_en
);
   // R4
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_overrun |=> latch_q.ovf);

   // R4
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q.ovf && !clr_ovf) |=> latch_q.ovf);

   // R5
   int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_int && !(|irq_evt)) |=> !latch_q.intr);

   // R10
   irq_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_evt) |=> irq_req);

   // R8
   index_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_above_half |=> !index_en);

   // R7
   trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |=> latch_q.trig);
endmodule

bind acq_status_reg acq_status_chk #(.N_IRQ_SRC(N_IRQ_SRC)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fifo_overrun    (fifo_overrun),
   .fifo_above_half (fifo_above_half),
   .irq_evt         (irq_evt),
   .clr_ovf         (clr_ovf),
   .clr_int         (clr_int),
   .trig_evt        (trig_evt),
   .latch_q         (latch_q),
   .irq_req         (irq_req),
   .index_en        (index_en));

// File: tb/sim_acq_status_reg.sv
`timescale 1ns/1ps
module sim_acq_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       layout_sel = 1'b1;
   logic       fifo_not_empty = 1'b0, fifo_above_half = 1'b0, fifo_overrun = 1'b0;
   logic [3:0] irq_evt = '0;
   logic       ext_irq_in = 1'b0, trig_in = 1'b0;
   logic       clr_ovf = 1'b0, clr_int = 1'b0, clr_xint = 1'b0, clr_trig = 1'b0;
   logic       pacer_fast = 1'b0;
   logic [3:0] mux_addr = '0;
   logic       inputs_single_ended = 1'b0, input_unipolar = 1'b0, conv_busy = 1'b0;
   logic [7:0] status_o;
   logic       irq_req, index_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the sticky flags and edge history
   bit m_ovf, m_xint, m_int, m_trig, m_gate, m_px, m_pt;

   always #2.5 clk = ~clk;

   acq_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel),
      .fifo_not_empty(fifo_not_empty), .fifo_above_half(fifo_above_half),
      .fifo_overrun(fifo_overrun), .irq_evt(irq_evt),
      .ext_irq_in(ext_irq_in), .trig_in(trig_in),
      .clr_ovf(clr_ovf), .clr_int(clr_int), .clr_xint(clr_xint), .clr_trig(clr_trig),
      .pacer_fast(pacer_fast), .mux_addr(mux_addr),
      .inputs_single_ended(inputs_single_ended), .input_unipolar(input_unipolar),
      .conv_busy(conv_busy), .status_o(status_o), .irq_req(irq_req), .index_en(index_en));

   function automatic logic [7:0] exp_status();
      if (layout_sel)
         return {pacer_fast, m_gate, m_trig, m_int, m_xint, m_ovf,
                 fifo_above_half, fifo_not_empty};
      return {conv_busy, input_unipolar, inputs_single_ended, m_int, mux_addr};
   endfunction

   task automatic model_edge();
      bit xr, tr;
      if (!rst_n) begin
         {m_ovf, m_xint, m_int, m_trig, m_gate, m_px, m_pt} = '0;
         return;
      end
      xr = ext_irq_in & ~m_px;
      tr = trig_in & ~m_pt;
      m_ovf  = fifo_overrun | (m_ovf  & ~clr_ovf);
      m_int  = (|irq_evt)   | (m_int  & ~clr_int);
      m_xint = xr           | (m_xint & ~clr_xint);
      m_trig = tr           | (m_trig & ~clr_trig);
      m_gate = fifo_above_half | (m_gate & ~clr_trig);
      m_px = ext_irq_in;
      m_pt = trig_in;
   endtask

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // one clock: inputs were set before the falling edge; model at rising edge; sample 1 ns later
   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      #1;
      check8(tag, status_o, exp_status());
      check8("R10 irq_req", {7'b0, irq_req}, {7'b0, m_int | m_xint});
      check8("R8 index_en", {7'b0, index_en}, {7'b0, ~m_gate});
      @(negedge clk);
   endtask

   task automatic quiet();
      fifo_overrun = 0; irq_evt = '0;
      clr_ovf = 0; clr_int = 0; clr_xint = 0; clr_trig = 0;
   endtask

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      fifo_above_half = 1'b1;           // present during reset: gate must stay clear
      repeat (3) @(negedge clk);
      @(posedge clk); model_edge(); #1;
      check8("R11 reset status", status_o, 8'h02);
      check8("R11 reset index_en", {7'b0, index_en}, 8'h01);
      @(negedge clk);
      fifo_above_half = 1'b0;
      rst_n = 1'b1;
      step("R11 after release");

      // R3 live flags follow inputs
      fifo_not_empty = 1; step("R3 not-empty live");
      fifo_not_empty = 0; step("R3 not-empty drops");

      // R4 overrun latch holds until its clear
      fifo_overrun = 1; step("R4 overrun set");
      quiet(); repeat (3) step("R4 overrun held");
      clr_int = 1; clr_xint = 1; clr_trig = 1; step("R4 foreign clears ignored");
      quiet(); clr_ovf = 1; step("R4 overrun cleared");
      // R9 set beats clear
      fifo_overrun = 1; clr_ovf = 1; step("R9 set wins overrun");
      quiet();

      // R5 on-board interrupt from each source
      for (int s = 0; s < 4; s++) begin
         irq_evt = 4'b1 << s; step("R5 source sets int");
         quiet(); clr_ovf = 1; clr_xint = 1; clr_trig = 1; step("R5 other clears no effect");
         quiet(); clr_int = 1; step("R5 int cleared");
         quiet();
      end

      // R6 external interrupt edge, level does not retrigger
      ext_irq_in = 1; step("R6 xint edge");
      quiet(); clr_xint = 1; step("R6 xint cleared");
      quiet(); repeat (3) step("R6 held level no re-set");
      ext_irq_in = 0; step("R6 line low");

      // R7 trigger edge and clear
      trig_in = 1; step("R7 trigger edge");
      trig_in = 0; clr_trig = 1; step("R7 trigger cleared");
      quiet(); trig_in = 1; clr_trig = 1; step("R9 set wins trigger");
      quiet(); trig_in = 0;

      // R8 index gate
      fifo_above_half = 1; step("R8 gate sets");
      fifo_above_half = 0; step("R8 gate held");
      clr_trig = 1; step("R8 gate cleared");
      quiet();

      // R2 compatible layout directed
      layout_sel = 0; mux_addr = 4'hA; inputs_single_ended = 1; input_unipolar = 0;
      conv_busy = 1; irq_evt = 4'b0100; step("R2 compatible byte");
      quiet(); clr_int = 1; step("R2 compatible int clear");
      quiet(); layout_sel = 1; pacer_fast = 1; step("R1 enhanced byte");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         layout_sel          = $urandom_range(0, 3) != 0;
         fifo_not_empty      = $urandom_range(0, 1);
         fifo_above_half     = $urandom_range(0, 7) == 0;
         fifo_overrun        = $urandom_range(0, 15) == 0;
         irq_evt             = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
         ext_irq_in          = ($urandom_range(0, 3) == 0) ? ~ext_irq_in : ext_irq_in;
         trig_in             = ($urandom_range(0, 3) == 0) ? ~trig_in : trig_in;
         clr_ovf             = $urandom_range(0, 7) == 0;
         clr_int             = $urandom_range(0, 7) == 0;
         clr_xint            = $urandom_range(0, 7) == 0;
         clr_trig            = $urandom_range(0, 7) == 0;
         pacer_fast          = $urandom_range(0, 1);
         mux_addr            = 4'($urandom_range(0, 15));
         inputs_single_ended = $urandom_range(0, 1);
         input_unipolar      = $urandom_range(0, 1);
         conv_busy           = $urandom_range(0, 1);
         step(layout_sel ? "R1 random enhanced" : "R2 random compatible");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule